// File: doc/BRIEF.md
# Capability Access Checker

This unit sits in front of the memory port and decides, one cycle after each load or store request, whether the access may proceed. An access covers 1 to 16 consecutive bytes starting at a request address. In capability mode the request carries its own capability. That capability is given as uncompressed fields: a lower bound, an exclusive upper bound one bit wider than an address, read and write permission bits, and a validity tag. The unit checks the access against those fields only.

In legacy mode the request carries a plain address and nothing else of use. The unit pairs that address with a global default capability held in an internal register. It then applies the same tag, permission and bounds tests. Software reads and replaces the default capability through a small register port. Out of reset the default covers the whole address space with both permissions and a set tag, so legacy traffic is unrestricted until it is narrowed.

Each response gives a valid strobe, a fault flag and a two-bit cause. When several violations hold at once, the cause reports the one with the highest priority.

Top module: `cap_guard`

## Requirements
- R1: An access whose effective capability has a clear tag gets cause 1 (tag). In capability mode the tag is `reqCapTag`. In legacy mode it is the tag of the default register.
- R2: A read needs read permission (permission bit 0) and a write needs write permission (permission bit 1). A missing permission gets cause 2 (permission).
- R3: An access passes the bounds test only if `addr >= base` and `addr + size <= top`, so that every byte lies in [base, top). Otherwise it gets cause 3 (bounds). With base 0x200 and top 0x204, a 4-byte write at 0x200 passes and a 5-byte write faults.
- R4: The end address `addr + size` is formed with a carry bit. An access that wraps past the highest address therefore gets a bounds fault and is never treated as small.
- R5: Tag takes priority over permission, and permission takes priority over bounds. The cause reports only the highest-priority violation.
- R6: In legacy mode (`reqMode` = 0) the request address is checked against the default register's base, top, permissions and tag. The capability fields on the request have no effect.
- R7: In capability mode (`reqMode` = 1) the default register has no effect on the result.
- R8: After reset the default register reads back as base 0, top 2^ADDR_W, and flags 3'b111. The flags are tag in bit 2, write in bit 1 and read in bit 0.
- R9: Register-port select 0 is base, 1 is top and 2 is flags. A write takes effect at the clock edge, and the read data follows the select without a clock. A legacy request in the same cycle as a write to the default register is checked against the value held before that write.
- R10: The response appears in the cycle after the request. `rspValid` is high for one cycle per request. The cause codes are 0 none, 1 tag, 2 permission and 3 bounds. `rspFault` is high exactly when the cause is not 0. With no request, `rspValid` and the cause stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request present |
| reqMode | input | 1 | 1 capability mode, 0 legacy mode |
| reqWrite | input | 1 | 1 store, 0 load |
| reqAddr | input | ADDR_W | First byte address |
| reqSize | input | SIZE_W | Byte count, 1 to MAX_BYTES |
| reqCapTag | input | 1 | Request capability tag |
| reqCapPerm | input | 2 | Request capability permissions, bit 1 write, bit 0 read |
| reqCapBase | input | ADDR_W | Request capability lower bound |
| reqCapTop | input | ADDR_W+1 | Request capability exclusive upper bound |
| regWrEn | input | 1 | Default register write strobe |
| regAddr | input | 2 | Default register field select |
| regWrData | input | ADDR_W+1 | Default register write data |
| regRdData | output | ADDR_W+1 | Selected default register field |
| rspValid | output | 1 | Result present |
| rspFault | output | 1 | Access refused |
| rspCause | output | 2 | Fault cause code |

## Verification
A legacy access and a write to the default register through the register port can land in the same cycle. The bench provokes this by narrowing the default register's flags so that stores lose write permission. It then issues a legacy store in the same cycle as a write that restores the flags. The store must be judged under the old flags and get cause 2. The next identical store must pass, which shows that the new value took effect at that edge. A second overlap does the same with the base field, while a request stream runs back to back so that the scoreboard also confirms that responses stay in order.

// File: rtl/cap_guard_pkg.sv
package cap_guard_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_TAG    = 2'd1,
    CAUSE_PERM   = 2'd2,
    CAUSE_BOUNDS = 2'd3
  } faultCause_t;

  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_TOP   = 2'd1;
  localparam logic [1:0] SEL_FLAGS = 2'd2;

  // Bit positions inside the flags field of the default register.
  localparam int FLAG_RD  = 0;
  localparam int FLAG_WR  = 1;
  localparam int FLAG_TAG = 2;

  typedef struct packed {
    logic capture;     // a request is being accepted this cycle
    logic useDefault;  // legacy request: derive capability from default reg
    logic ldBase;
    logic ldTop;
    logic ldFlags;
  } ctrlStrobe_t;

endpackage

// File: rtl/cap_guard_ctrl.sv
module cap_guard_ctrl
  import cap_guard_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqMode,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe            = '0;
    strobe.capture    = reqValid;
    strobe.useDefault = reqValid && !reqMode;
    if (regWrEn) begin
      unique case (regAddr)
        SEL_BASE:  strobe.ldBase  = 1'b1;
        SEL_TOP:   strobe.ldTop   = 1'b1;
        SEL_FLAGS: strobe.ldFlags = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/cap_guard_chk.sv
module cap_guard_chk
  import cap_guard_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 5
) (
  input  logic              tag,
  input  logic              permRd,
  input  logic              permWr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   top,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              isWrite,
  output faultCause_t       cause
);

  localparam int PAD_W = ADDR_W + 1 - SIZE_W;

  logic [ADDR_W:0] endAddr;
  logic            belowBase;
  logic            pastTop;
  logic            permOk;

  // Carry bit kept so a wrapped end address compares above any top.
  assign endAddr   = {1'b0, addr} + {{PAD_W{1'b0}}, size};
  assign belowBase = addr < base;
  assign pastTop   = endAddr > top;
  assign permOk    = isWrite ? permWr : permRd;

  always_comb begin
    if (!tag)                       cause = CAUSE_TAG;
    else if (!permOk)               cause = CAUSE_PERM;
    else if (belowBase || pastTop)  cause = CAUSE_BOUNDS;
    else                            cause = CAUSE_NONE;
  end

endmodule

// File: rtl/cap_guard_dp.sv
module cap_guard_dp
  import cap_guard_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqCapTag,
  input  logic [1:0]        reqCapPerm,
  input  logic [ADDR_W-1:0] reqCapBase,
  input  logic [ADDR_W:0]   reqCapTop,
  input  logic [1:0]        regAddr,
  input  logic [ADDR_W:0]   regWrData,
  output logic [ADDR_W:0]   regRdData,
  output logic              rspValid,
  output logic [1:0]        rspCause
);

  localparam logic [ADDR_W:0] FULL_TOP = {1'b1, {ADDR_W{1'b0}}};
  localparam int              FLAG_PAD = ADDR_W + 1 - 3;

  logic [ADDR_W-1:0] defBase;
  logic [ADDR_W:0]   defTop;
  logic              defRd, defWr, defTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      defBase <= '0;
      defTop  <= FULL_TOP;
      defRd   <= 1'b1;
      defWr   <= 1'b1;
      defTag  <= 1'b1;
    end else begin
      if (strobe.ldBase)  defBase <= regWrData[ADDR_W-1:0];
      if (strobe.ldTop)   defTop  <= regWrData;
      if (strobe.ldFlags) begin
        defRd  <= regWrData[FLAG_RD];
        defWr  <= regWrData[FLAG_WR];
        defTag <= regWrData[FLAG_TAG];
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      SEL_BASE:  regRdData = {1'b0, defBase};
      SEL_TOP:   regRdData = defTop;
      SEL_FLAGS: regRdData = {{FLAG_PAD{1'b0}}, defTag, defWr, defRd};
      default:   regRdData = '0;
    endcase
  end

  // Effective capability: the default register in legacy mode, else the request's own.
  logic              effTag, effRd, effWr;
  logic [ADDR_W-1:0] effBase;
  logic [ADDR_W:0]   effTop;

  always_comb begin
    if (strobe.useDefault) begin
      effTag  = defTag;
      effRd   = defRd;
      effWr   = defWr;
      effBase = defBase;
      effTop  = defTop;
    end else begin
      effTag  = reqCapTag;
      effRd   = reqCapPerm[FLAG_RD];
      effWr   = reqCapPerm[FLAG_WR];
      effBase = reqCapBase;
      effTop  = reqCapTop;
    end
  end

  faultCause_t cause;

  cap_guard_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) chk_i (
    .tag     (effTag),
    .permRd  (effRd),
    .permWr  (effWr),
    .base    (effBase),
    .top     (effTop),
    .addr    (reqAddr),
    .size    (reqSize),
    .isWrite (reqWrite),
    .cause   (cause)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCause <= CAUSE_NONE;
    end else begin
      rspValid <= strobe.capture;
      rspCause <= strobe.capture ? cause : CAUSE_NONE;
    end
  end

endmodule

// File: rtl/cap_guard.sv
module cap_guard
  import cap_guard_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int MAX_BYTES = 16,
  localparam int SIZE_W   = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqMode,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqCapTag,
  input  logic [1:0]        reqCapPerm,
  input  logic [ADDR_W-1:0] reqCapBase,
  input  logic [ADDR_W:0]   reqCapTop,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [ADDR_W:0]   regWrData,
  output logic [ADDR_W:0]   regRdData,
  output logic              rspValid,
  output logic              rspFault,
  output logic [1:0]        rspCause
);

  ctrlStrobe_t strobe;

  cap_guard_ctrl ctrl_i (
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .strobe   (strobe)
  );

  cap_guard_dp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqCapTag  (reqCapTag),
    .reqCapPerm (reqCapPerm),
    .reqCapBase (reqCapBase),
    .reqCapTop  (reqCapTop),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .rspValid   (rspValid),
    .rspCause   (rspCause)
  );

  assign rspFault = rspCause != CAUSE_NONE;

endmodule

// File: rtl/cap_guard_sva.sv
module cap_guard_sva
  import cap_guard_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqMode,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqCapTag,
  input logic [1:0]        reqCapPerm,
  input logic [ADDR_W-1:0] reqCapBase,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic [ADDR_W:0]   regWrData,
  input logic [ADDR_W:0]   regRdData,
  input logic              rspValid,
  input logic [1:0]        rspCause
);

  logic capPermOk;
  assign capPermOk = reqWrite ? reqCapPerm[1] : reqCapPerm[0];

  // R10
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && rspCause == 2'd0));

  // R1
  untagged_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode && !reqCapTag) |=> rspCause == 2'd1);

  // R2
  perm_missing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode && reqCapTag && !capPermOk) |=> rspCause == 2'd2);

  // R3
  below_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode && reqCapTag && capPermOk && (reqAddr < reqCapBase))
      |=> rspCause == 2'd3);

  // R9
  top_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == SEL_TOP)
      |=> (regAddr != SEL_TOP || regRdData == $past(regWrData)));

endmodule

bind cap_guard cap_guard_sva #(.ADDR_W(ADDR_W)) sva_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqMode    (reqMode),
  .reqWrite   (reqWrite),
  .reqAddr    (reqAddr),
  .reqCapTag  (reqCapTag),
  .reqCapPerm (reqCapPerm),
  .reqCapBase (reqCapBase),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .rspValid   (rspValid),
  .rspCause   (rspCause)
);

// File: tb/cap_guard_tb_top.sv
module cap_guard_tb_top;

  localparam int AW = 64;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqMode = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [SW-1:0] reqSize = '0;
  logic          reqCapTag = 1'b0;
  logic [1:0]    reqCapPerm = '0;
  logic [AW-1:0] reqCapBase = '0;
  logic [AW:0]   reqCapTop = '0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regAddr = '0;
  logic [AW:0]   regWrData = '0;
  logic [AW:0]   regRdData;
  logic          rspValid, rspFault;
  logic [1:0]    rspCause;

  always #10 clk = ~clk;  // 50 MHz

  cap_guard dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqCapTag(reqCapTag), .reqCapPerm(reqCapPerm), .reqCapBase(reqCapBase),
    .reqCapTop(reqCapTop), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rspValid(rspValid),
    .rspFault(rspFault), .rspCause(rspCause)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] expQ[$];
  string      tagQ[$];

  // Bench copy of the default register, kept from the requirements.
  logic [AW-1:0] mBase  = '0;
  logic [AW:0]   mTop   = {1'b1, {AW{1'b0}}};
  logic [2:0]    mFlags = 3'b111;

  localparam logic [AW:0]   FULL = {1'b1, {AW{1'b0}}};
  localparam logic [AW-1:0] MAXA = {AW{1'b1}};

  function automatic logic [1:0] model(input logic write, input logic [AW-1:0] addr,
      input logic [SW-1:0] size, input logic tag, input logic [1:0] perm,
      input logic [AW-1:0] base, input logic [AW:0] top);
    logic [AW:0] endA;
    endA = {1'b0, addr} + {{(AW+1-SW){1'b0}}, size};
    if (!tag) return 2'd1;
    if (!(write ? perm[1] : perm[0])) return 2'd2;
    if (addr < base || endA > top) return 2'd3;
    return 2'd0;
  endfunction

  task automatic fail(input string req, input string what,
                      input logic [AW:0] act, input logic [AW:0] exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // Driver: one request per call, optional same-cycle register write.
  task automatic drive(input string req, input logic mode, input logic write,
      input logic [AW-1:0] addr, input logic [SW-1:0] size,
      input logic tag, input logic [1:0] perm,
      input logic [AW-1:0] base, input logic [AW:0] top,
      input logic wr = 1'b0, input logic [1:0] sel = 2'd0,
      input logic [AW:0] wdata = '0);
    logic [1:0] e;
    @(negedge clk);
    if (mode) e = model(write, addr, size, tag, perm, base, top);
    else      e = model(write, addr, size, mFlags[2], mFlags[1:0], mBase, mTop);
    expQ.push_back(e);
    tagQ.push_back(req);
    reqValid = 1'b1; reqMode = mode; reqWrite = write; reqAddr = addr;
    reqSize = size; reqCapTag = tag; reqCapPerm = perm;
    reqCapBase = base; reqCapTop = top;
    regWrEn = wr; regAddr = sel; regWrData = wdata;
    if (wr) begin
      if (sel == 2'd0) mBase = wdata[AW-1:0];
      else if (sel == 2'd1) mTop = wdata;
      else if (sel == 2'd2) mFlags = wdata[2:0];
    end
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [AW:0] d);
    @(negedge clk);
    reqValid = 1'b0; regWrEn = 1'b1; regAddr = sel; regWrData = d;
    if (sel == 2'd0) mBase = d[AW-1:0];
    else if (sel == 2'd1) mTop = d;
    else if (sel == 2'd2) mFlags = d[2:0];
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(input string req, input logic [1:0] sel, input logic [AW:0] exp);
    @(negedge clk);
    reqValid = 1'b0; regWrEn = 1'b0; regAddr = sel;
    #2;
    checks++;
    if (regRdData !== exp) fail(req, "regRdData", regRdData, exp);
  endtask

  // Monitor: samples mid high phase, pops the scoreboard.
  always @(posedge clk) begin
    logic [1:0] e;
    string      t;
    #5;
    if (rstN && rspValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fail("R10", "unexpected rspValid", 1, 0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rspCause !== e) fail(t, "rspCause", rspCause, e);
        else if (rspFault !== (e != 2'd0)) fail(t, "rspFault", rspFault, (e != 2'd0));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R10 reset state
    if (rspValid !== 1'b0) fail("R10", "rspValid in reset", rspValid, 0);
    rstN = 1'b1;

    // R8 reset value of the default register
    regCheck("R8", 2'd0, '0);
    regCheck("R8", 2'd1, FULL);
    regCheck("R8", 2'd2, 65'h7);

    // R6 legacy accesses against the full default; R4 wrap at the top
    drive("R6", 0, 0, 64'h1234, 5'd8, 0, 2'b00, '0, '0);
    drive("R3", 0, 1, MAXA, 5'd1, 0, 2'b00, '0, '0);
    drive("R4", 0, 0, MAXA, 5'd2, 1, 2'b11, '0, FULL);
    idle();
    @(negedge clk);
    checks++;  // R10 idle cycle stays quiet
    if (rspValid !== 1'b0 || rspCause !== 2'd0) fail("R10", "idle rsp", rspValid, 0);

    // R3 bounds of a 4-byte region at 0x200
    drive("R3", 1, 1, 64'h200, 5'd4, 1, 2'b11, 64'h200, 65'h204);
    drive("R3", 1, 1, 64'h200, 5'd5, 1, 2'b11, 64'h200, 65'h204);
    drive("R3", 1, 0, 64'h1FF, 5'd1, 1, 2'b11, 64'h200, 65'h204);
    drive("R3", 1, 0, 64'h203, 5'd1, 1, 2'b11, 64'h200, 65'h204);
    drive("R3", 1, 0, 64'h204, 5'd1, 1, 2'b11, 64'h200, 65'h204);
    // R1, R2, R5
    drive("R1", 1, 0, 64'h200, 5'd1, 0, 2'b11, 64'h200, 65'h204);
    drive("R5", 1, 1, 64'h300, 5'd16, 0, 2'b00, 64'h200, 65'h204);
    drive("R5", 1, 1, 64'h300, 5'd16, 1, 2'b01, 64'h200, 65'h204);
    drive("R2", 1, 0, 64'h200, 5'd2, 1, 2'b10, 64'h200, 65'h204);
    drive("R2", 1, 1, 64'h200, 5'd2, 1, 2'b01, 64'h200, 65'h204);
    // R4 wrap in capability mode
    drive("R4", 1, 0, MAXA - 64'd3, 5'd8, 1, 2'b11, '0, FULL);
    drive("R4", 1, 0, MAXA - 64'd3, 5'd4, 1, 2'b11, '0, FULL);
    idle();

    // R9 narrow the default register and read it back
    regWrite(2'd0, 65'h1000);
    regWrite(2'd1, 65'h1010);
    regCheck("R9", 2'd0, 65'h1000);
    regCheck("R9", 2'd1, 65'h1010);
    // R6 legacy now bounded; request capability fields ignored
    drive("R6", 0, 0, 64'h1000, 5'd16, 0, 2'b00, 64'h9000, 65'h9001);
    drive("R6", 0, 0, 64'h1008, 5'd16, 1, 2'b11, '0, FULL);
    drive("R6", 0, 1, 64'h0FFF, 5'd1, 1, 2'b11, '0, FULL);
    // R7 capability mode ignores the narrowed default
    drive("R7", 1, 1, 64'h5000, 5'd16, 1, 2'b11, 64'h5000, 65'h5010);
    idle();

    // R1 untagged default; R2 read-only default
    regWrite(2'd2, 65'h3);
    drive("R1", 0, 0, 64'h1000, 5'd1, 1, 2'b11, '0, FULL);
    idle();
    regWrite(2'd2, 65'h5);
    regCheck("R9", 2'd2, 65'h5);
    drive("R2", 0, 1, 64'h1000, 5'd1, 1, 2'b11, '0, FULL);
    drive("R2", 0, 0, 64'h1000, 5'd1, 1, 2'b11, '0, FULL);
    // R9 same-cycle write: request sees the old flags, the next one the new
    drive("R9", 0, 1, 64'h1004, 5'd4, 1, 2'b11, '0, FULL, 1'b1, 2'd2, 65'h7);
    drive("R9", 0, 1, 64'h1004, 5'd4, 1, 2'b11, '0, FULL);
    // R9 same-cycle base write
    drive("R9", 0, 0, 64'h0800, 5'd4, 1, 2'b11, '0, FULL, 1'b1, 2'd0, 65'h0800);
    drive("R9", 0, 0, 64'h0800, 5'd4, 1, 2'b11, '0, FULL);
    idle();
    regCheck("R9", 2'd0, 65'h0800);

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) fail("R10", "missing responses", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule